// File: doc/BRIEF.md
# Chroma Bilinear Sub-Pixel Interpolator

This block produces fractional-position chroma prediction rows from a reference block whose two colour components are stored interleaved, one byte each, alternating along the row. A start pulse captures a horizontal and a vertical eighth-sample offset, a width code and an output row count. Reference rows then arrive one per input beat. Each input row after the first is blended with the row before it, using four corner weights derived from the offsets. The result is one output row of rounded, clamped 8-bit samples, still interleaved.

Every input row is used twice: first as the lower row of one output and then as the upper row of the next. A block of N output rows therefore consumes N+1 input rows. The output is a registered valid/ready stage. A new input row can be accepted in the same cycle that the previous result leaves, so under continuous flow the block delivers one row per clock. After the final row is taken, a one-cycle done pulse marks the end of the block and the interpolator goes back to idle.

Top module: `chroma_bilerp`

## Requirements
- R1: With offsets x and y in 0..7, the weights are Wa=(8-x)(8-y), Wb=x(8-y), Wc=(8-x)y and Wd=xy. Output byte k equals min(255, (Wa·u[k] + Wb·u[k+2] + Wc·l[k] + Wd·l[k+2] + 32) >> 6), where u is the upper (older) row and l is the lower (newer) row. Byte k sits at bits [8k+7:8k] of each row bus.
- R2: The horizontal neighbour of byte k is byte k+2, the next sample of the same colour component, and never byte k+1.
- R3: With both offsets zero, every active output byte equals the matching byte of the upper row exactly.
- R4: Width code 0 gives 4 active output bytes, code 1 gives 8, and codes 2 and 3 give 16. Output bytes above the active count are zero.
- R5: A block of N rows (1..255) accepts exactly N+1 input rows and emits exactly N output rows, in order.
- R6: While idle, in_ready and out_valid are low, so input beats are not consumed.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_row holds its value.
- R8: done is high for exactly one cycle: the cycle after the final output row is accepted. busy is low from that cycle on.
- R9: Offsets, width code and row count are captured only by a start pulse seen while idle. A start pulse or changed inputs during a block have no effect on its results.
- R10: After reset, out_valid, in_ready, done and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; parameters are captured while idle |
| frac_x | input | 3 | Horizontal eighth-sample offset |
| frac_y | input | 3 | Vertical eighth-sample offset |
| width_sel | input | 2 | Width code (0: 4 bytes, 1: 8 bytes, 2/3: 16 bytes) |
| rows | input | HT_W | Number of output rows, 1 or more |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Input row accepted when high together with in_valid |
| in_row | input | (MAX_OUT+2)*8 | Reference row, byte k at bits [8k+7:8k] |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Downstream accepts the output row |
| out_row | output | MAX_OUT*8 | Interpolated row, byte k at bits [8k+7:8k] |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse after the last row is accepted |

## Verification
The case of interest is a single clock edge on which an output row is accepted downstream and, at the same time, the next reference row is taken in to overwrite the output register and the stored upper row. The bench provokes this by running some blocks with out_ready held high, which makes both handshakes fire on nearly every edge. It runs other blocks with periodic or alternating backpressure, which separates the two handshakes. Each accepted row is compared with a model computed from the weighting rule, and the bench requires that the concurrent handshake occurred at least once, so a row that is lost or duplicated on that edge shows up as a mismatch or as a wrong row count.

// File: rtl/chroma_bilerp.sv
`timescale 1ns/1ps
module chroma_bilerp #(
  parameter int MAX_OUT = 16,
  parameter int HT_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2:0]               frac_x,
  input  logic [2:0]               frac_y,
  input  logic [1:0]               width_sel,
  input  logic [HT_W-1:0]          rows,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [(MAX_OUT+2)*8-1:0] in_row,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [MAX_OUT*8-1:0]     out_row,
  output logic                     busy,
  output logic                     done
);
  localparam int IW = (MAX_OUT + 2) * 8;
  localparam int OW = MAX_OUT * 8;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_RUN, S_DRAIN} st_t;

  st_t             st;
  logic [2:0]      dx_q, dy_q;
  logic [1:0]      ws_q;
  logic [HT_W-1:0] rem;
  logic [IW-1:0]   prev_q;
  logic [OW-1:0]   out_q;
  logic            out_v, done_q;
  logic [OW-1:0]   lane_val;

  logic [3:0] nx, ny;
  logic [6:0] wa, wb, wc, wd;
  assign nx = 4'd8 - {1'b0, dx_q};
  assign ny = 4'd8 - {1'b0, dy_q};
  assign wa = {3'b0, nx} * {3'b0, ny};
  assign wb = {4'b0, dx_q} * {3'b0, ny};
  assign wc = {3'b0, nx} * {4'b0, dy_q};
  assign wd = {4'b0, dx_q} * {4'b0, dy_q};

  for (genvar k = 0; k < MAX_OUT; k++) begin : g_lane
    logic [15:0] acc;
    logic        en;
    assign acc = 16'(wa) * 16'(prev_q[8*k +: 8])
               + 16'(wb) * 16'(prev_q[8*(k+2) +: 8])
               + 16'(wc) * 16'(in_row[8*k +: 8])
               + 16'(wd) * 16'(in_row[8*(k+2) +: 8])
               + 16'd32;
    assign en = (ws_q == 2'd0) ? (k < 4) : (ws_q == 2'd1) ? (k < 8) : 1'b1;
    assign lane_val[8*k +: 8] = !en ? 8'h00 : (acc[15:14] != 2'b00) ? 8'hFF : acc[13:6];
  end

  assign in_ready  = (st == S_FIRST) || ((st == S_RUN) && (!out_v || out_ready));
  assign out_valid = out_v;
  assign out_row   = out_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;

  logic in_fire, out_fire;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_v && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dx_q   <= '0;
      dy_q   <= '0;
      ws_q   <= '0;
      rem    <= '0;
      prev_q <= '0;
      out_q  <= '0;
      out_v  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (in_fire && st == S_RUN) out_v <= 1'b1;
      else if (out_fire)          out_v <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          dx_q <= frac_x;
          dy_q <= frac_y;
          ws_q <= width_sel;
          rem  <= rows;
          st   <= S_FIRST;
        end
        S_FIRST: if (in_fire) begin
          prev_q <= in_row;
          st     <= S_RUN;
        end
        S_RUN: if (in_fire) begin
          prev_q <= in_row;
          out_q  <= lane_val;
          rem    <= rem - 1'b1;
          if (rem == HT_W'(1)) st <= S_DRAIN;
        end
        S_DRAIN: if (out_fire) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready) && !busy);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready && !out_valid);
  p_row_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && st == S_RUN |=> out_valid);
endmodule

// File: tb/chroma_bilerp_test.sv
`timescale 1ns/1ps
module chroma_bilerp_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   frac_x = '0, frac_y = '0;
  logic [1:0]   width_sel = '0;
  logic [7:0]   rows = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [143:0] in_row = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_row;
  logic         busy, done;

  int checks = 0;
  int fails  = 0;
  int concurrent = 0;

  always #10 clk = ~clk;

  chroma_bilerp uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frac_x(frac_x), .frac_y(frac_y),
    .width_sel(width_sel), .rows(rows), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .busy(busy), .done(done)
  );

  // {dx, dy, width code, rows, seed, ready mode}
  localparam logic [23:0] VEC [8] = '{
    {3'd0, 3'd0, 2'd2, 8'd3, 6'd5,  2'd0},
    {3'd7, 3'd7, 2'd2, 8'd4, 6'd0,  2'd1},
    {3'd4, 3'd0, 2'd0, 8'd2, 6'd6,  2'd0},
    {3'd3, 3'd5, 2'd1, 8'd5, 6'd7,  2'd2},
    {3'd0, 3'd6, 2'd2, 8'd2, 6'd9,  2'd1},
    {3'd7, 3'd0, 2'd1, 8'd1, 6'd3,  2'd0},
    {3'd2, 3'd2, 2'd0, 8'd4, 6'd4,  2'd2},
    {3'd5, 3'd3, 2'd3, 8'd6, 6'd11, 2'd0}
  };
  localparam string TAG [8] = '{"R3", "R1", "R2", "R4", "R1", "R5", "R4", "R1"};

  function automatic logic [7:0] src(int seed, int r, int k);
    if (seed == 0) return 8'hFF;
    return 8'((seed * 37 + r * 53 + k * k * 11 + (k % 2) * 97) & 255);
  endfunction

  function automatic logic [143:0] mkrow(int seed, int r);
    logic [143:0] v;
    for (int k = 0; k < 18; k++) v[8*k +: 8] = src(seed, r, k);
    return v;
  endfunction

  function automatic logic [127:0] model(int dx, int dy, int ws, int seed, int r);
    logic [127:0] v = '0;
    int nb = (ws == 0) ? 4 : (ws == 1) ? 8 : 16;
    for (int k = 0; k < nb; k++) begin
      int s = (8-dx)*(8-dy)*src(seed, r, k) + dx*(8-dy)*src(seed, r, k+2)
            + (8-dx)*dy*src(seed, r+1, k) + dx*dy*src(seed, r+1, k+2) + 32;
      s = s >> 6;
      if (s > 255) s = 255;
      v[8*k +: 8] = 8'(s);
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_entry(int e);
    int dx = int'(VEC[e][23:21]);
    int dy = int'(VEC[e][20:18]);
    int ws = int'(VEC[e][17:16]);
    int ht = int'(VEC[e][15:8]);
    int seed = int'(VEC[e][7:2]);
    int mode = int'(VEC[e][1:0]);
    int fed = 0, got = 0, cyc = 0;
    bit hold_v = 0;
    logic [127:0] hold_row = '0;
    @(negedge clk);
    in_valid = 1'b1;
    in_row = mkrow(99, 0);
    #1;
    check(!in_ready, "R6", 128'(in_ready), 128'(0));
    frac_x = 3'(dx); frac_y = 3'(dy); width_sel = 2'(ws); rows = 8'(ht);
    start = 1'b1;
    @(negedge clk);
    frac_x = ~frac_x; frac_y = ~frac_y; width_sel = 2'd0; rows = 8'd9;
    while (got < ht) begin
      cyc++;
      start = (cyc == 3);  // R9: start during a block is ignored
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 3 != 0);
      in_valid = (fed <= ht);
      in_row = mkrow(seed, fed);
      #1;
      if (hold_v) begin
        check(out_valid && out_row == hold_row, "R7", out_row, hold_row);
        hold_v = 0;
      end
      if (in_valid && in_ready && out_valid && out_ready) concurrent++;
      if (out_valid && out_ready) begin
        logic [127:0] ex = model(dx, dy, ws, seed, got);
        check(out_row == ex, TAG[e], out_row, ex);
        got++;
      end else if (out_valid) begin
        hold_v = 1;
        hold_row = out_row;
      end
      if (in_valid && in_ready) fed++;
      @(negedge clk);
    end
    start = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    check(done && !busy, "R8", 128'({done, busy}), 128'(2'b10));
    check(fed == ht + 1, "R5", 128'(fed), 128'(ht + 1));
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    check(!done, "R8", 128'(done), 128'(0));
    check(!in_ready && !out_valid, "R6", 128'({in_ready, out_valid}), 128'(0));
    in_valid = 1'b0;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    check(!out_valid && !in_ready && !done && !busy, "R10",
          128'({out_valid, in_ready, done, busy}), 128'(0));
    for (int e = 0; e < 8; e++) run_entry(e);
    check(concurrent > 0, "R5", 128'(concurrent), 128'(1));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule